// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This core encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It is built for small area: a single round datapath is reused for all ten rounds, and the round key is derived on the fly from the previous one, so no expanded key store is needed. The round datapath is a bank of 256-entry tables, each with 16-bit words. One half of each word holds the substituted byte and the other half holds that byte doubled in GF(2^8). The tables feed one XOR network that performs column mixing and key addition together. The row rotation is done purely by how the table addresses are wired.

A requester places the key and the plaintext on the inputs and raises `start` for one cycle. The inputs are captured in that cycle, and the initial key addition is applied as they are loaded. `busy` then stays high for the ten round cycles. At the end, `done` pulses and `text_out` presents the ciphertext. That value stays there until the next block finishes. A request made during the `done` cycle is accepted, so blocks can run back to back with no gap.

Top module: `aes_it_core`

## Requirements
- R1: `text_out` equals the AES-128 encryption of `text_in` under `key_in`. Byte 0 of each 128-bit vector is bits [127:120], and bytes are packed column by column (byte 4c+r is row r of column c).
- R2: The key and plaintext are sampled only in the cycle a request is accepted. Later changes to `key_in` or `text_in` do not alter the result of the block in progress.
- R3: `busy` rises in the cycle after an accepted request and stays high for exactly 10 cycles.
- R4: `done` is high for exactly one cycle, in the cycle right after the last `busy` cycle, and is never high together with `busy`.
- R5: A `start` raised while `busy` is high is ignored. The running block keeps its timing and its result.
- R6: `text_out` changes only in the cycle in which `done` is high. Between completions, including during a following block, it keeps the last result.
- R7: While `rst` is high and after it is released, `busy` and `done` are low and `text_out` is zero until a block completes.
- R8: A request made while `done` is high is accepted, and the next block then starts at once.
- R9: The last of the ten rounds leaves out column mixing. The round constants run 01, 02, 04, …, 80, 1B, 36, produced by GF doubling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to encrypt one block |
| key_in | input | 128 | Cipher key |
| text_in | input | 128 | Plaintext block |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle completion pulse |
| text_out | output | 128 | Ciphertext of the last completed block |

## Verification
The published standard test vectors pin down the byte order, the last-round behaviour and the full constant sequence (R1, R9). Random keys and plaintexts from a fixed seed exercise every table entry and every key-schedule path. All-zero and all-ones inputs expose stuck or inverted lines. During some blocks the bench changes the inputs and raises `start` again while the block is running, to show that the capture and the ignore rule hold. Other blocks are chained from the `done` cycle or follow idle gaps, to separate correct back-to-back acceptance from correct holding of the output.

// File: rtl/aes_it_pkg.sv
package aes_it_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUND = 2'd1,
    ST_DONE  = 2'd2
  } fsm_e;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_dbl(input byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // inverse as a^254, zero maps to zero
  function automatic byte_t gf_inv(input byte_t a);
    byte_t res;
    byte_t base;
    logic [7:0] ex;
    res  = 8'h01;
    base = a;
    ex   = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (ex[i]) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic byte_t rotl8(input byte_t b, input int n);
    return byte_t'((b << n) | (b >> (8 - n)));
  endfunction

  function automatic byte_t sub_calc(input byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // table word: upper byte = doubled substitute, lower byte = substitute
  function automatic logic [15:0] merged_word(input byte_t a);
    byte_t s;
    s = sub_calc(a);
    return {gf_dbl(s), s};
  endfunction

endpackage

// File: rtl/aes_it_mrom.sv
module aes_it_mrom #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  import aes_it_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] tbl [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      tbl[i] = DW'(merged_word(byte_t'(i)));
    end
  end

  assign q = tbl[addr];

endmodule

// File: rtl/aes_it_mixadd.sv
module aes_it_mixadd #(
  parameter int ROWS = 4
) (
  input  logic [8*ROWS-1:0] sb_i,
  input  logic [8*ROWS-1:0] db_i,
  input  logic [8*ROWS-1:0] key_i,
  input  logic              last_i,
  output logic [8*ROWS-1:0] col_o
);
  localparam int CW = 8 * ROWS;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int R1 = (r + 1) % ROWS;
    localparam int R2 = (r + 2) % ROWS;
    localparam int R3 = (r + 3) % ROWS;
    logic [7:0] mixed;
    logic [7:0] plain;
    // 2*a_r ^ 3*a_{r+1} ^ a_{r+2} ^ a_{r+3}, with 3*x = 2*x ^ x
    assign mixed = db_i[CW-1-8*r -: 8]
                 ^ db_i[CW-1-8*R1 -: 8] ^ sb_i[CW-1-8*R1 -: 8]
                 ^ sb_i[CW-1-8*R2 -: 8]
                 ^ sb_i[CW-1-8*R3 -: 8];
    assign plain = sb_i[CW-1-8*r -: 8];
    assign col_o[CW-1-8*r -: 8] = (last_i ? plain : mixed) ^ key_i[CW-1-8*r -: 8];
  end

endmodule

// File: rtl/aes_it_round.sv
module aes_it_round #(
  parameter int BLK_W = 128
) (
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  localparam int NBYTE = BLK_W / 8;
  localparam int NROW  = 4;
  localparam int NCOL  = NBYTE / NROW;
  localparam int CW    = 8 * NROW;

  logic [BLK_W-1:0] sb_all;
  logic [BLK_W-1:0] db_all;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_row
      // row rotation realised in the address wiring
      localparam int SRC = NROW * ((c + r) % NCOL) + r;
      localparam int DST = NROW * c + r;
      logic [15:0] word;
      aes_it_mrom #(.AW(8), .DW(16)) u_tbl (
        .addr (state_i[BLK_W-1-8*SRC -: 8]),
        .q    (word)
      );
      assign sb_all[BLK_W-1-8*DST -: 8] = word[7:0];
      assign db_all[BLK_W-1-8*DST -: 8] = word[15:8];
    end

    aes_it_mixadd #(.ROWS(NROW)) u_mix (
      .sb_i   (sb_all[BLK_W-1-CW*c -: CW]),
      .db_i   (db_all[BLK_W-1-CW*c -: CW]),
      .key_i  (rkey_i[BLK_W-1-CW*c -: CW]),
      .last_i (last_i),
      .col_o  (state_o[BLK_W-1-CW*c -: CW])
    );
  end

endmodule

// File: rtl/aes_it_keystep.sv
module aes_it_keystep #(
  parameter int KEY_W = 128
) (
  input  logic [KEY_W-1:0] rk_i,
  input  logic [7:0]       rcon_i,
  output logic [KEY_W-1:0] rk_o
);
  localparam int NWORD = KEY_W / 32;

  logic [31:0] rot_w;
  logic [31:0] sub_w;
  logic [31:0] mix_w;

  // rotate the last word left by one byte
  assign rot_w = {rk_i[23:0], rk_i[31:24]};

  for (genvar j = 0; j < 4; j++) begin : g_sub
    logic [15:0] word;
    aes_it_mrom #(.AW(8), .DW(16)) u_tbl (
      .addr (rot_w[31-8*j -: 8]),
      .q    (word)
    );
    assign sub_w[31-8*j -: 8] = word[7:0];
  end

  assign mix_w = sub_w ^ {rcon_i, 24'h000000};

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    if (w == 0) begin : g_first
      assign rk_o[KEY_W-1 -: 32] = rk_i[KEY_W-1 -: 32] ^ mix_w;
    end else begin : g_rest
      assign rk_o[KEY_W-1-32*w -: 32] = rk_i[KEY_W-1-32*w -: 32]
                                        ^ rk_o[KEY_W-1-32*(w-1) -: 32];
    end
  end

endmodule

// File: rtl/aes_it_ctrl.sv
module aes_it_ctrl #(
  parameter int ROUNDS = 10,
  parameter int CNT_W  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  import aes_it_pkg::*;

  fsm_e             fsm_q;
  logic [CNT_W-1:0] rnd_q;

  assign load = start && (fsm_q != ST_ROUND);
  assign step = (fsm_q == ST_ROUND);
  assign last = step && (rnd_q == CNT_W'(ROUNDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q <= ST_IDLE;
      rnd_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (fsm_q)
        ST_IDLE, ST_DONE: begin
          done <= 1'b0;
          if (start) begin
            fsm_q <= ST_ROUND;
            rnd_q <= CNT_W'(1);
            busy  <= 1'b1;
          end else begin
            fsm_q <= ST_IDLE;
          end
        end
        ST_ROUND: begin
          if (rnd_q == CNT_W'(ROUNDS)) begin
            fsm_q <= ST_DONE;
            rnd_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            rnd_q <= rnd_q + CNT_W'(1);
          end
        end
        default: begin
          fsm_q <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/aes_it_core.sv
module aes_it_core #(
  parameter int          BLK_W     = 128,
  parameter int          ROUNDS    = 10,
  parameter logic [7:0]  RCON_INIT = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] key_in,
  input  logic [BLK_W-1:0] text_in,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] text_out
);
  import aes_it_pkg::*;

  localparam int CNT_W = $clog2(ROUNDS + 1);

  logic             load;
  logic             step;
  logic             last;
  logic [BLK_W-1:0] state_q;
  logic [BLK_W-1:0] rk_q;
  logic [7:0]       rcon_q;
  logic [BLK_W-1:0] rk_next;
  logic [BLK_W-1:0] state_next;

  aes_it_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  aes_it_keystep #(.KEY_W(BLK_W)) u_key (
    .rk_i   (rk_q),
    .rcon_i (rcon_q),
    .rk_o   (rk_next)
  );

  aes_it_round #(.BLK_W(BLK_W)) u_round (
    .state_i (state_q),
    .rkey_i  (rk_next),
    .last_i  (last),
    .state_o (state_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= '0;
      rk_q     <= '0;
      rcon_q   <= RCON_INIT;
      text_out <= '0;
    end else if (load) begin
      state_q <= text_in ^ key_in;
      rk_q    <= key_in;
      rcon_q  <= RCON_INIT;
    end else if (step) begin
      state_q <= state_next;
      rk_q    <= rk_next;
      rcon_q  <= gf_dbl(rcon_q);
      if (last) text_out <= state_next;
    end
  end

endmodule

// File: rtl/aes_it_chk.sv
module aes_it_chk #(
  parameter int BLK_W  = 128,
  parameter int ROUNDS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [BLK_W-1:0] text_out
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (start && !busy) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 8'd1;
  end

  a_r3_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r3_ten_busy_cycles: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == 8'(ROUNDS)));

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_not_both: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r5_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  a_r6_out_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(text_out) |-> done);

endmodule

bind aes_it_core aes_it_chk #(.BLK_W(BLK_W), .ROUNDS(ROUNDS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .text_out (text_out)
);

// File: tb/aes_it_core_tb.sv
module aes_it_core_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [127:0] key_in;
  logic [127:0] text_in;
  logic         busy;
  logic         done;
  logic [127:0] text_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  logic [127:0] exp_last = '0;

  logic [7:0] sb_ref [256];
  logic [7:0] lg_ref [256];
  logic [7:0] ex_ref [256];

  always #10 clk = ~clk;

  aes_it_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .key_in   (key_in),
    .text_in  (text_in),
    .busy     (busy),
    .done     (done),
    .text_out (text_out)
  );

  function automatic logic [7:0] x2(input logic [7:0] b);
    logic [7:0] r;
    r = b << 1;
    if (b[7]) r = r ^ 8'h1b;
    return r;
  endfunction

  // substitution table built from exp/log tables with generator 3
  task automatic build_sbox();
    logic [7:0] e;
    logic [7:0] inv;
    logic [7:0] c;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex_ref[i] = e;
      lg_ref[e] = 8'(i);
      e = e ^ x2(e);
    end
    c = 8'h63;
    for (int a = 0; a < 256; a++) begin
      if (a == 0) inv = 8'h00;
      else inv = ex_ref[(255 - int'(lg_ref[a])) % 255];
      for (int i = 0; i < 8; i++) begin
        sb_ref[a][i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                       ^ inv[(i+7)%8] ^ c[i];
      end
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] st [16];
    logic [7:0] rk [16];
    logic [7:0] tm [16];
    logic [7:0] rc;
    logic [7:0] t [4];
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      rk[i] = k[127-8*i -: 8];
      st[i] = p[127-8*i -: 8] ^ rk[i];
    end
    rc = 8'h01;
    for (int rnd = 1; rnd <= 10; rnd++) begin
      t[0] = sb_ref[rk[13]] ^ rc;
      t[1] = sb_ref[rk[14]];
      t[2] = sb_ref[rk[15]];
      t[3] = sb_ref[rk[12]];
      for (int i = 0; i < 4; i++) rk[i] = rk[i] ^ t[i];
      for (int i = 4; i < 16; i++) rk[i] = rk[i] ^ rk[i-4];
      rc = x2(rc);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          tm[4*c+r] = sb_ref[st[4*((c+r)%4)+r]];
      if (rnd < 10) begin
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++) begin
            st[4*c+r] = x2(tm[4*c+r]) ^ x2(tm[4*c+(r+1)%4]) ^ tm[4*c+(r+1)%4]
                        ^ tm[4*c+(r+2)%4] ^ tm[4*c+(r+3)%4];
          end
        end
      end else begin
        for (int i = 0; i < 16; i++) st[i] = tm[i];
      end
      for (int i = 0; i < 16; i++) st[i] = st[i] ^ rk[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = st[i];
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // drive a request so that the next rising edge accepts it
  task automatic launch(input logic [127:0] k, input logic [127:0] p);
    start   = 1'b1;
    key_in  = k;
    text_in = p;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called at the falling edge after the accepting edge
  task automatic follow(input logic [127:0] exp, input bit disturb, input bit chain,
                        input logic [127:0] nk, input logic [127:0] np);
    check(busy === 1'b1, "R3", "busy after accept", 128'(busy), 128'd1);
    for (int i = 1; i <= 9; i++) begin
      if (disturb) begin
        key_in  = rnd128();
        text_in = rnd128();
        start   = i[0];   // R5: requests while busy
      end
      @(negedge clk);
      check(busy === 1'b1 && done === 1'b0, "R3", "busy during rounds",
            128'({busy, done}), 128'b10);
      check(text_out === exp_last, "R6", "output held during block", text_out, exp_last);
    end
    start = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b1, "R4", "done after ten cycles",
          128'({busy, done}), 128'b01);
    check(text_out === exp, disturb ? "R2" : "R1", "ciphertext", text_out, exp);
    exp_last = exp;
    if (chain) begin
      launch(nk, np);
      check(done === 1'b0, "R8", "done pulse ends when chained", 128'(done), 128'd0);
    end else begin
      @(negedge clk);
      check(done === 1'b0, "R4", "done single cycle", 128'(done), 128'd0);
      check(text_out === exp, "R6", "output held after done", text_out, exp);
    end
  endtask

  initial begin
    logic [127:0] ka, pa, kb, pb, k, p, k2, p2;
    void'($urandom(32'h5eed_a11e));
    build_sbox();
    rst = 1'b1; start = 1'b1; key_in = '0; text_in = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R7", "idle during reset",
          128'({busy, done}), 128'd0);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R7", "busy after reset", 128'(busy), 128'd0);
    check(done === 1'b0, "R7", "done after reset", 128'(done), 128'd0);
    check(text_out === 128'd0, "R7", "output after reset", text_out, 128'd0);

    // standard vectors: byte order, last round and constant sequence (R1, R9)
    ka = 128'h000102030405060708090a0b0c0d0e0f;
    pa = 128'h00112233445566778899aabbccddeeff;
    kb = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    pb = 128'h3243f6a8885a308d313198a2e0370734;
    check(ref_enc(ka, pa) === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R9",
          "bench model vector", ref_enc(ka, pa), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    launch(ka, pa);
    follow(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, 1'b0, '0, '0);
    launch(kb, pb);
    follow(128'h3925841d02dc09fbdc118597196a0b32, 1'b1, 1'b0, '0, '0);

    // chained from the done cycle (R8)
    launch(ka, pb);
    follow(ref_enc(ka, pb), 1'b0, 1'b1, kb, pa);
    follow(ref_enc(kb, pa), 1'b0, 1'b0, '0, '0);

    // corner patterns
    launch('0, '0);
    follow(ref_enc('0, '0), 1'b0, 1'b0, '0, '0);
    launch('1, '1);
    follow(ref_enc('1, '1), 1'b1, 1'b0, '0, '0);

    // random blocks, mixing disturbance, chaining and idle gaps
    for (int n = 0; n < 24; n++) begin
      k = rnd128();
      p = rnd128();
      launch(k, p);
      if (n % 4 == 3) begin
        k2 = rnd128();
        p2 = rnd128();
        follow(ref_enc(k, p), n[0], 1'b1, k2, p2);
        follow(ref_enc(k2, p2), 1'b0, 1'b0, '0, '0);
      end else begin
        follow(ref_enc(k, p), n[0], 1'b0, '0, '0);
        key_in  = rnd128();
        text_in = rnd128();
        repeat (n % 3) @(negedge clk);
        check(busy === 1'b0 && text_out === exp_last, "R6", "idle hold",
              text_out, exp_last);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL R3 watchdog: got %h expected %h", 128'd0, 128'd1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule